// File: doc/BRIEF.md
# Quasi-Resonant Switch Restart Controller

This block decides on every clock edge whether the gate of a flyback power switch is high or low. Its inputs are already-digitised comparator outputs: a level that goes high when the auxiliary winding crosses its zero-current threshold, a current-sense trip level, a single-cycle pulse from an external VCO, a mode flag that selects free-running or frequency-foldback operation, and an enable. It drives one gate output.

In free-running mode, the rising edge of the demagnetization level turns the switch on, so each cycle starts in the drain valley. In foldback mode, a VCO pulse is first held in a latch, and the next demagnetization edge after that starts the cycle. A timeout covers ringing that has decayed too far to cross the threshold. Once the timeout has run out, a VCO pulse alone starts the cycle in either mode. Three further rules apply to every cycle:
- Turn-on edges are spaced by a minimum period, which is how the maximum switching rate is clamped.
- The current-sense trip is ignored for a blanking window after each turn-on.
- Dropping the enable forces the gate low at once.

All durations are parameters in clock cycles.

Top module: `qr_restart_ctrl`

## Requirements
- R1: In free-running mode (`fold_mode_i` = 0), a rising edge of `demag_i` sampled while the gate is off and the minimum period has elapsed sets `gate_o` high after that clock edge.
- R2: In foldback mode (`fold_mode_i` = 1), a `demag_i` rising edge alone does not turn the switch on. It does so only if a `vco_pulse_i` was captured at an earlier edge and has not yet been consumed.
- R3: An off-time timer of `TIMEOUT_CYC` cycles is reloaded by each accepted `demag_i` edge, by every edge with the gate on, and by every edge with the enable low. After it has run out, a `vco_pulse_i` starts a cycle in either mode. A VCO pulse seen before expiry does not start a cycle through this path.
- R4: A `cs_trip_i` high sampled on the `BLANK_CYC` edges that follow a turn-on edge is ignored. A trip sampled on a later edge drops the gate at that edge, so the on-time with the trip held high is `BLANK_CYC`+1 cycles.
- R5: Two turn-on edges are at least `MIN_PERIOD_CYC` clock cycles apart. A start request that comes earlier is dropped and is not deferred.
- R6: While `en_i` is low, `gate_o` is low in the same cycle, without waiting for a clock edge. A captured VCO pulse is cleared and the timeout timer is reloaded.
- R7: A `demag_i` rising edge that arrives while the gate is on is discarded. It is not held for the next cycle.
- R8: The VCO capture is cleared on every turn-on, so one VCO pulse enables at most one cycle.
- R9: While `rst_ni` is low, and after reset until a start condition occurs, `gate_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low forces the gate off |
| demag_i | input | 1 | Zero-current comparator level; its rising edge marks a valley |
| cs_trip_i | input | 1 | Current-sense comparator trip level |
| vco_pulse_i | input | 1 | One-cycle clock pulse from the VCO |
| fold_mode_i | input | 1 | 0 = free-running, 1 = frequency foldback |
| gate_o | output | 1 | Switch gate command |

## Verification
A free-running cycle-by-cycle sequence checks the following:
- A trip held from the first on-cycle separates blanked edges from honoured ones.
- A valley edge one cycle before the period limit is rejected.
- A valley edge during the on-time is followed by a cycle in which a stored edge would have fired.
- A VCO pulse before and after timer expiry distinguishes the timeout path from a bare VCO start.

Foldback sequences apply a valley edge with and without a prior VCO pulse, and a second valley edge after the pulse was consumed, which shows the latch is single-use. Enable tests check the gate between clock edges and show that a VCO pulse captured before the enable drop no longer counts.

// File: rtl/qrr_pkg.sv
package qrr_pkg;
  typedef enum logic {MODE_FREE = 1'b0, MODE_FOLD = 1'b1} qrr_mode_e;

  function automatic int unsigned cnt_w(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/qrr_down_timer.sv
module qrr_down_timer #(
  parameter int unsigned LOAD_VAL = 1,
  parameter int unsigned RST_VAL  = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);
  localparam int unsigned MaxV = (LOAD_VAL > RST_VAL) ? LOAD_VAL : RST_VAL;
  localparam int unsigned W    = qrr_pkg::cnt_w(MaxV);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= W'(RST_VAL);
    else if (load_i)      cnt_q <= W'(LOAD_VAL);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  a_r3_load_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (LOAD_VAL == 0) || !zero_o);
endmodule

// File: rtl/qrr_start_arb.sv
module qrr_start_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic demag_i,
  input  logic vco_pulse_i,
  input  logic fold_mode_i,
  input  logic gate_q_i,
  input  logic period_ok_i,
  input  logic to_zero_i,
  output logic fire_o,
  output logic dm_acc_o,
  output logic vco_lat_o
);
  import qrr_pkg::*;

  logic      demag_q, vco_lat_q, dm_rise, to_sync, req;
  qrr_mode_e mode;

  assign mode    = qrr_mode_e'(fold_mode_i);
  assign dm_rise = demag_i & ~demag_q;
  // edges during the on-time are dropped (not stored)
  assign dm_acc_o = dm_rise & ~gate_q_i;
  assign to_sync  = to_zero_i & vco_pulse_i;

  always_comb begin
    unique case (mode)
      MODE_FREE: req = dm_acc_o | to_sync;
      MODE_FOLD: req = (dm_acc_o & vco_lat_q) | to_sync;
      default:   req = 1'b0;
    endcase
  end

  assign fire_o = en_i & ~gate_q_i & period_ok_i & req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      demag_q   <= 1'b0;
      vco_lat_q <= 1'b0;
    end else begin
      demag_q   <= demag_i;
      vco_lat_q <= en_i & ~fire_o & (vco_pulse_i | vco_lat_q);
    end
  end

  assign vco_lat_o = vco_lat_q;

  // R8: a turn-on consumes the capture
  a_r8_lat_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !vco_lat_q);
  // R6: disable empties the capture
  a_r6_lat_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !vco_lat_q);
endmodule

// File: rtl/qr_restart_ctrl.sv
module qr_restart_ctrl #(
  parameter int unsigned BLANK_CYC      = 40,
  parameter int unsigned MIN_PERIOD_CYC = 1600,
  parameter int unsigned TIMEOUT_CYC    = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic demag_i,
  input  logic cs_trip_i,
  input  logic vco_pulse_i,
  input  logic fold_mode_i,
  output logic gate_o
);
  localparam int unsigned PeriodLoad = (MIN_PERIOD_CYC > 1) ? MIN_PERIOD_CYC - 1 : 0;

  logic gate_q, fire, dm_acc, vco_lat;
  logic blank_zero, period_zero, to_zero, to_load;

  assign to_load = ~en_i | gate_q | dm_acc;

  qrr_down_timer #(.LOAD_VAL(BLANK_CYC), .RST_VAL(0)) u_blank (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(fire), .zero_o(blank_zero));

  qrr_down_timer #(.LOAD_VAL(PeriodLoad), .RST_VAL(0)) u_period (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(fire), .zero_o(period_zero));

  qrr_down_timer #(.LOAD_VAL(TIMEOUT_CYC), .RST_VAL(TIMEOUT_CYC)) u_timeout (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(to_load), .zero_o(to_zero));

  qrr_start_arb u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .demag_i(demag_i),
    .vco_pulse_i(vco_pulse_i), .fold_mode_i(fold_mode_i), .gate_q_i(gate_q),
    .period_ok_i(period_zero), .to_zero_i(to_zero), .fire_o(fire),
    .dm_acc_o(dm_acc), .vco_lat_o(vco_lat));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gate_q <= 1'b0;
    else if (!en_i)  gate_q <= 1'b0;
    else if (gate_q) gate_q <= ~(cs_trip_i & blank_zero);
    else             gate_q <= fire;
  end

  assign gate_o = gate_q & en_i;

  a_r6_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gate_o);
  a_r4_blank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q && en_i && !blank_zero) |=> gate_q);
  a_r5_min_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q) |-> $past(period_zero));
  a_r2_fold_needs_vco: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gate_q) && $past(fold_mode_i)) |-> $past(vco_lat || (to_zero && vco_pulse_i)));
  a_r1_free_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !gate_q && period_zero && dm_acc && !fold_mode_i) |=> gate_q);
endmodule

// File: tb/tb_qr_restart_ctrl.sv
`timescale 1ns/1ps
module tb_qr_restart_ctrl;
  localparam int unsigned BLK = 3, PER = 10, TMO = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, dm = 1'b0, trip = 1'b0, vco = 1'b0, fold = 1'b0;
  logic gate;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  qr_restart_ctrl #(.BLANK_CYC(BLK), .MIN_PERIOD_CYC(PER), .TIMEOUT_CYC(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .demag_i(dm), .cs_trip_i(trip),
    .vco_pulse_i(vco), .fold_mode_i(fold), .gate_o(gate));

  // {en, demag, trip, vco, fold, expected gate after the edge}
  localparam logic [5:0] VEC [29] = '{
    6'b100000, 6'b110001, 6'b111001, 6'b101001, 6'b101001, 6'b101000,
    6'b100000, 6'b110000, 6'b100000, 6'b100000, 6'b110000, 6'b100000,
    6'b110001, 6'b100001, 6'b110001, 6'b101001, 6'b101000, 6'b100000,
    6'b100000, 6'b100000, 6'b100100, 6'b100000, 6'b100000, 6'b100101,
    6'b101001, 6'b101001, 6'b101001, 6'b101000, 6'b100000};

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gate_o act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic d, input logic t, input logic v,
                      input logic f, input logic exp, input string tag);
    en = e; dm = d; trip = t; vco = v; fold = f;
    @(posedge clk);
    @(negedge clk);
    chk(gate, exp, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; dm = 1'b0; trip = 1'b0; vco = 1'b0; fold = 1'b0;
    repeat (3) @(negedge clk);
    chk(gate, 1'b0, "R9 in reset");
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // free-running table: R1 start, R4 blanking, R5 spacing, R7 discard, R3 timeout
    do_reset();
    for (int i = 0; i < 29; i++) begin
      en = VEC[i][5]; dm = VEC[i][4]; trip = VEC[i][3]; vco = VEC[i][2]; fold = VEC[i][1];
      @(posedge clk);
      @(negedge clk);
      chk(gate, VEC[i][0], $sformatf("table R1 R3 R4 R5 R7 row %0d", i));
    end

    // R9: idle after reset
    do_reset();
    step(1,0,0,0,0, 0, "R9 idle after reset");
    step(1,0,0,0,0, 0, "R9 idle after reset");

    // R2 and R8: foldback needs a captured VCO pulse, consumed by one cycle
    do_reset();
    step(1,0,0,0,1, 0, "R2 idle");
    step(1,1,0,0,1, 0, "R2 demag without vco");
    step(1,0,0,0,1, 0, "R2 idle");
    step(1,0,0,1,1, 0, "R2 vco captured");
    step(1,0,0,0,1, 0, "R2 waiting");
    step(1,1,0,0,1, 1, "R2 demag after vco");
    step(1,0,1,0,1, 1, "R4 blank");
    step(1,0,1,0,1, 1, "R4 blank");
    step(1,0,1,0,1, 1, "R4 blank");
    step(1,0,1,0,1, 0, "R4 trip honoured");
    for (int k = 0; k < 5; k++) step(1,0,0,0,1, 0, "R3 no vco no restart");
    step(1,1,0,0,1, 0, "R8 capture consumed");
    step(1,0,0,1,1, 0, "R8 new capture");
    step(1,0,0,0,1, 0, "R8 waiting");
    step(1,1,0,0,1, 1, "R8 second capture used");

    // R6: gate drops within the cycle
    do_reset();
    step(1,1,0,0,0, 1, "R1 demag start");
    en = 1'b0; dm = 1'b0;
    #1 chk(gate, 1'b0, "R6 immediate low");
    @(posedge clk);
    @(negedge clk);
    chk(gate, 1'b0, "R6 stays low");
    step(1,0,0,0,0, 0, "R6 no restart on enable");

    // R6: disable clears captured VCO pulse
    do_reset();
    step(1,0,0,1,1, 0, "R6 vco captured");
    step(0,0,0,0,1, 0, "R6 disabled");
    step(1,1,0,0,1, 0, "R6 capture lost");
    step(1,0,0,0,1, 0, "R6 idle");
    step(1,0,0,1,1, 0, "R3 vco before expiry");
    step(1,1,0,0,1, 1, "R2 fresh capture works");

    // R3: timeout restart in foldback, synchronized to VCO
    do_reset();
    for (int k = 0; k < 6; k++) step(1,0,0,0,1, 0, "R3 expiring");
    step(1,0,0,1,1, 1, "R3 timeout plus vco");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule